// File: doc/BRIEF.md
# Instruction Byte Field Splitter

This block accepts instruction bytes one at a time over a valid/ready handshake and breaks each instruction into its parts. It handles one or two opcode bytes, an optional addressing-mode byte, an optional scale-index-base byte, an optional displacement and an optional immediate. Each byte can change the size of the fields that follow it, so the block walks through the fields in order as a byte-serial state machine. When an instruction is complete it raises a one-cycle `done` and holds every extracted field steady for that cycle.

A small built-in class table over a reduced opcode subset decides two things for each opcode: whether an addressing-mode byte follows, and how long the immediate is. A single `mode32` input sets both the operand size and the address size. The parser samples `mode32` when it accepts the first opcode byte of an instruction. Prefix bytes, execution and address arithmetic are outside this block.

States and transitions: `ST_OPC` takes the first byte. From `ST_OPC`, an escape byte 0x0F goes to `ST_OPC2`. Otherwise, and also from `ST_OPC2`, the parser goes to `ST_MODRM` if the class needs an addressing byte, else to `ST_IMM` if the class has an immediate, else to `ST_DONE`. `ST_MODRM` goes to `ST_SIB` when a scale-index-base byte is needed. Otherwise `ST_MODRM` and `ST_SIB` go to `ST_DISP` when a displacement is present, else to `ST_IMM` or `ST_DONE`. `ST_DISP` stays put until its last byte, then goes to `ST_IMM` or `ST_DONE`. `ST_IMM` stays put until its last byte, then goes to `ST_DONE`. `ST_DONE` always returns to `ST_OPC` on the next cycle.

Top module: `insn_field_parser`

## Requirements
- R1: The first byte accepted is the first opcode byte. If it equals 0x0F, the next byte is a second opcode byte, and at `done` `op_two`=1 and `op_second` holds that byte. Otherwise `op_two`=0 and `op_second`=0.
- R2: Opcode classes, where "full" means 4 bytes when `mode32`=1 and 2 bytes when `mode32`=0.
  - Single-byte opcodes b below 0x40 are classed by b[2:0]. A value of 0 to 3 means an addressing byte and no immediate. A value of 4 means a 1-byte immediate. A value of 5 means a full immediate.
  - 0x68 takes a full immediate. 0x6A takes a sign-extended 1-byte immediate.
  - 0x80 takes an addressing byte and a 1-byte immediate. 0x81 takes an addressing byte and a full immediate. 0x83 takes an addressing byte and a sign-extended 1-byte immediate.
  - 0x88 to 0x8B take an addressing byte only.
  - 0xB0 to 0xB7 take a 1-byte immediate. 0xB8 to 0xBF take a full immediate.
  - 0xC6 takes an addressing byte and a 1-byte immediate. 0xC7 takes an addressing byte and a full immediate.
  - For second opcode bytes, 0x80 to 0x8F take a full immediate, and 0x90 to 0xBF take an addressing byte. Every other opcode takes nothing.
- R3: The addressing byte follows the opcode directly. Its layout is mod in [7:6], reg in [5:3] and r/m in [2:0]. When `mode32`=1, mod≠3 and r/m=4, a scale-index-base byte follows, with its base field in bits [2:0]. No such byte is ever used when `mode32`=0.
- R4: Displacement length when `mode32`=1: mod=1 gives 1 byte and mod=2 gives 4 bytes. mod=0 gives 4 bytes when r/m=5, or when r/m=4 and the base field is 5. Every other case gives none.
- R5: Displacement length when `mode32`=0: mod=1 gives 1 byte, mod=2 gives 2 bytes, and mod=0 with r/m=6 gives 2 bytes. Every other case gives none.
- R6: The displacement is assembled little-endian into `disp_val`, and so is the immediate into `imm_val`. The immediate always comes last. Bits above each field's length are zero.
- R7: `imm_ext` equals `imm_val`, except for a sign-extended 1-byte immediate. In that case bit 7 is copied up to bit 31 when `mode32`=1, or up to bit 15 with the upper half zero when `mode32`=0.
- R8: `done` goes high for exactly one cycle, in the cycle after the last byte is accepted. `in_ready` is low during that cycle and high in the cycle after it. `insn_len` counts every byte of the instruction.
- R9: A byte is taken only in a cycle with `in_valid` and `in_ready` both high. Cycles with `in_valid` low change no field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode32 | input | 1 | 1 selects 32-bit operand and address size, 0 selects 16-bit |
| in_valid | input | 1 | Byte on `in_byte` is valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Parser can take a byte |
| done | output | 1 | One-cycle pulse marking that all fields are complete |
| op_first | output | 8 | First opcode byte |
| op_second | output | 8 | Second opcode byte, or 0 |
| op_two | output | 1 | Two-byte opcode seen |
| modrm_seen | output | 1 | Addressing byte present |
| modrm | output | 8 | Addressing byte |
| sib_seen | output | 1 | Scale-index-base byte present |
| sib | output | 8 | Scale-index-base byte |
| disp_bytes | output | 3 | Displacement length in bytes |
| disp_val | output | 32 | Displacement, little-endian assembled |
| imm_bytes | output | 3 | Immediate length in bytes |
| imm_val | output | 32 | Raw immediate |
| imm_ext | output | 32 | Immediate extended to operand size |
| insn_len | output | 4 | Total bytes in the instruction |

## Verification
Every possible first opcode byte is sent in both modes. This covers each class and the difference between 2-byte and 4-byte full immediates. Every second opcode byte after the escape is also sent, which separates the immediate, addressing and empty second-byte classes. All 256 addressing bytes are tried in both modes to cover every displacement rule. Every scale-index-base value is swept under mod 0, 1 and 2, which isolates the base-5 displacement case. The immediate's leading byte runs through both signs, and idle cycles carrying a junk byte are mixed into a third of the instructions to show that only handshaken bytes are taken.

// File: rtl/ifp_pkg.sv
`timescale 1ns/1ps
package ifp_pkg;

    typedef enum logic [2:0] {
        ST_OPC   = 3'd0,
        ST_OPC2  = 3'd1,
        ST_MODRM = 3'd2,
        ST_SIB   = 3'd3,
        ST_DISP  = 3'd4,
        ST_IMM   = 3'd5,
        ST_DONE  = 3'd6
    } ifp_state_e;

    localparam logic [7:0] ESCAPE_OPC = 8'h0F;

    // Per-opcode class: addressing byte needed, immediate length, sign-extend flag
    typedef struct packed {
        logic       need_modrm;
        logic [2:0] imm_len;
        logic       imm_sext;
    } ifp_class_t;

endpackage

// File: rtl/ifp_opclass.sv
`timescale 1ns/1ps
module ifp_opclass
    import ifp_pkg::*;
(
    input  logic       mode32,
    input  logic       two_byte,
    input  logic [7:0] opc,
    output ifp_class_t cls
);
    logic [2:0] full_len;

    always_comb begin
        full_len = mode32 ? 3'd4 : 3'd2;
        cls      = '0;
        if (two_byte) begin
            if (opc[7:4] == 4'h8) begin
                cls.imm_len = full_len;
            end else if (opc >= 8'h90 && opc <= 8'hBF) begin
                cls.need_modrm = 1'b1;
            end
        end else if (opc < 8'h40) begin
            unique case (opc[2:0])
                3'd0, 3'd1, 3'd2, 3'd3: cls.need_modrm = 1'b1;
                3'd4:                   cls.imm_len = 3'd1;
                3'd5:                   cls.imm_len = full_len;
                default:                cls = '0;
            endcase
        end else begin
            unique case (opc)
                8'h68: cls.imm_len = full_len;
                8'h6A: begin cls.imm_len = 3'd1; cls.imm_sext = 1'b1; end
                8'h80: begin cls.need_modrm = 1'b1; cls.imm_len = 3'd1; end
                8'h81: begin cls.need_modrm = 1'b1; cls.imm_len = full_len; end
                8'h83: begin cls.need_modrm = 1'b1; cls.imm_len = 3'd1; cls.imm_sext = 1'b1; end
                8'h88, 8'h89, 8'h8A, 8'h8B: cls.need_modrm = 1'b1;
                8'hC6: begin cls.need_modrm = 1'b1; cls.imm_len = 3'd1; end
                8'hC7: begin cls.need_modrm = 1'b1; cls.imm_len = full_len; end
                default: begin
                    if (opc[7:4] == 4'hB) cls.imm_len = opc[3] ? full_len : 3'd1;
                end
            endcase
        end
    end
endmodule

// File: rtl/ifp_ea_decode.sv
`timescale 1ns/1ps
module ifp_ea_decode #(
    parameter int CNT_W = 3
) (
    input  logic             mode32,
    input  logic [1:0]       mod_f,
    input  logic [2:0]       rm_f,
    input  logic             base_known,
    input  logic [2:0]       base_f,
    output logic             need_sib,
    output logic [CNT_W-1:0] disp_len
);
    always_comb begin
        need_sib = 1'b0;
        disp_len = '0;
        if (mode32) begin
            need_sib = (mod_f != 2'd3) && (rm_f == 3'd4);
            unique case (mod_f)
                2'd1: disp_len = CNT_W'(1);
                2'd2: disp_len = CNT_W'(4);
                2'd0: begin
                    if (rm_f == 3'd5 || (rm_f == 3'd4 && base_known && base_f == 3'd5))
                        disp_len = CNT_W'(4);
                end
                default: disp_len = '0;
            endcase
        end else begin
            unique case (mod_f)
                2'd1: disp_len = CNT_W'(1);
                2'd2: disp_len = CNT_W'(2);
                2'd0: if (rm_f == 3'd6) disp_len = CNT_W'(2);
                default: disp_len = '0;
            endcase
        end
    end
endmodule

// File: rtl/ifp_le_field.sv
`timescale 1ns/1ps
module ifp_le_field #(
    parameter int BYTES = 4,
    localparam int IDX_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   idx,
    input  logic [7:0]         din,
    output logic [8*BYTES-1:0] value
);
    logic [7:0] lane_q [BYTES];

    for (genvar j = 0; j < BYTES; j++) begin : g_lane
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                lane_q[j] <= '0;
            else if (clear)
                lane_q[j] <= '0;
            else if (wr_en && idx == IDX_W'(j))
                lane_q[j] <= din;
        end
        assign value[8*j +: 8] = lane_q[j];
    end
endmodule

// File: rtl/insn_field_parser.sv
`timescale 1ns/1ps
module insn_field_parser
    import ifp_pkg::*;
#(
    parameter int MAX_BYTES = 4,
    parameter int LEN_W     = 4,
    localparam int CNT_W    = $clog2(MAX_BYTES) + 1,
    localparam int IDX_W    = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
    localparam int FIELD_W  = 8 * MAX_BYTES
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mode32,
    input  logic               in_valid,
    input  logic [7:0]         in_byte,
    output logic               in_ready,
    output logic               done,
    output logic [7:0]         op_first,
    output logic [7:0]         op_second,
    output logic               op_two,
    output logic               modrm_seen,
    output logic [7:0]         modrm,
    output logic               sib_seen,
    output logic [7:0]         sib,
    output logic [CNT_W-1:0]   disp_bytes,
    output logic [FIELD_W-1:0] disp_val,
    output logic [CNT_W-1:0]   imm_bytes,
    output logic [FIELD_W-1:0] imm_val,
    output logic [FIELD_W-1:0] imm_ext,
    output logic [LEN_W-1:0]   insn_len
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ifp_state_e        state_q, state_d;
    ifp_class_t        cls, cls_q;
    logic              mode_q;
    logic              cls_mode;
    logic              acc;
    logic              is_escape;
    logic [CNT_W-1:0]  fcnt_q;
    logic [7:0]        dec_modrm;
    logic              need_sib;
    logic [CNT_W-1:0]  dlen;
    logic              disp_last, imm_last;

    assign in_ready  = (state_q != ST_DONE);
    assign done      = (state_q == ST_DONE);
    assign acc       = in_valid && in_ready;
    assign is_escape = (in_byte == ESCAPE_OPC);
    assign cls_mode  = (state_q == ST_OPC) ? mode32 : mode_q;
    assign dec_modrm = (state_q == ST_MODRM) ? in_byte : modrm;
    assign disp_last = (fcnt_q == disp_bytes - ONE);
    assign imm_last  = (fcnt_q == cls_q.imm_len - ONE);

    ifp_opclass u_opclass (
        .mode32   (cls_mode),
        .two_byte (state_q == ST_OPC2),
        .opc      (in_byte),
        .cls      (cls)
    );

    ifp_ea_decode #(.CNT_W(CNT_W)) u_ea (
        .mode32     (mode_q),
        .mod_f      (dec_modrm[7:6]),
        .rm_f       (dec_modrm[2:0]),
        .base_known (state_q == ST_SIB),
        .base_f     (in_byte[2:0]),
        .need_sib   (need_sib),
        .disp_len   (dlen)
    );

    ifp_le_field #(.BYTES(MAX_BYTES)) u_disp (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc && state_q == ST_OPC),
        .wr_en (acc && state_q == ST_DISP),
        .idx   (fcnt_q[IDX_W-1:0]),
        .din   (in_byte),
        .value (disp_val)
    );

    ifp_le_field #(.BYTES(MAX_BYTES)) u_imm (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (acc && state_q == ST_OPC),
        .wr_en (acc && state_q == ST_IMM),
        .idx   (fcnt_q[IDX_W-1:0]),
        .din   (in_byte),
        .value (imm_val)
    );

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OPC: if (acc) begin
                if (is_escape)                state_d = ST_OPC2;
                else if (cls.need_modrm)      state_d = ST_MODRM;
                else if (cls.imm_len != '0)   state_d = ST_IMM;
                else                          state_d = ST_DONE;
            end
            ST_OPC2: if (acc) begin
                if (cls.need_modrm)           state_d = ST_MODRM;
                else if (cls.imm_len != '0)   state_d = ST_IMM;
                else                          state_d = ST_DONE;
            end
            ST_MODRM: if (acc) begin
                if (need_sib)                 state_d = ST_SIB;
                else if (dlen != '0)          state_d = ST_DISP;
                else if (cls_q.imm_len != '0) state_d = ST_IMM;
                else                          state_d = ST_DONE;
            end
            ST_SIB: if (acc) begin
                if (dlen != '0)               state_d = ST_DISP;
                else if (cls_q.imm_len != '0) state_d = ST_IMM;
                else                          state_d = ST_DONE;
            end
            ST_DISP: if (acc && disp_last) begin
                state_d = (cls_q.imm_len != '0) ? ST_IMM : ST_DONE;
            end
            ST_IMM: if (acc && imm_last) state_d = ST_DONE;
            ST_DONE: state_d = ST_OPC;
            default: state_d = ST_OPC;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OPC;
        else        state_q <= state_d;
    end

    // Field registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_first   <= '0;
            op_second  <= '0;
            op_two     <= 1'b0;
            modrm_seen <= 1'b0;
            modrm      <= '0;
            sib_seen   <= 1'b0;
            sib        <= '0;
            disp_bytes <= '0;
            cls_q      <= '0;
            mode_q     <= 1'b0;
            fcnt_q     <= '0;
            insn_len   <= '0;
        end else if (acc) begin
            unique case (state_q)
                ST_OPC: begin
                    op_first   <= in_byte;
                    op_second  <= '0;
                    op_two     <= is_escape;
                    modrm_seen <= 1'b0;
                    modrm      <= '0;
                    sib_seen   <= 1'b0;
                    sib        <= '0;
                    disp_bytes <= '0;
                    cls_q      <= is_escape ? '0 : cls;
                    mode_q     <= mode32;
                    fcnt_q     <= '0;
                    insn_len   <= LEN_W'(1);
                end
                ST_OPC2: begin
                    op_second <= in_byte;
                    cls_q     <= cls;
                    insn_len  <= insn_len + 1'b1;
                end
                ST_MODRM: begin
                    modrm      <= in_byte;
                    modrm_seen <= 1'b1;
                    disp_bytes <= need_sib ? '0 : dlen;
                    insn_len   <= insn_len + 1'b1;
                end
                ST_SIB: begin
                    sib        <= in_byte;
                    sib_seen   <= 1'b1;
                    disp_bytes <= dlen;
                    insn_len   <= insn_len + 1'b1;
                end
                ST_DISP, ST_IMM: begin
                    fcnt_q   <= ((state_q == ST_DISP) ? disp_last : imm_last) ? '0 : fcnt_q + ONE;
                    insn_len <= insn_len + 1'b1;
                end
                default: fcnt_q <= '0;
            endcase
        end
    end

    assign imm_bytes = cls_q.imm_len;

    always_comb begin
        imm_ext = imm_val;
        if (cls_q.imm_sext && cls_q.imm_len == ONE) begin
            if (mode_q)
                imm_ext = {{(FIELD_W-8){imm_val[7]}}, imm_val[7:0]};
            else
                imm_ext = {{(FIELD_W-16){1'b0}}, {8{imm_val[7]}}, imm_val[7:0]};
        end
    end
endmodule

// File: rtl/ifp_checker.sv
`timescale 1ns/1ps
module ifp_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        done,
    input logic [7:0]  op_first,
    input logic        op_two,
    input logic        modrm_seen,
    input logic [7:0]  modrm,
    input logic        sib_seen,
    input logic [2:0]  disp_bytes,
    input logic [2:0]  imm_bytes,
    input logic [31:0] imm_ext,
    input logic [3:0]  insn_len
);
    a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r8_stall_in_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !in_ready);

    a_r8_ready_after: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> in_ready);

    a_r8_len_sum: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (insn_len == 4'(4'd1 + 4'(op_two) + 4'(modrm_seen) + 4'(sib_seen)
                                 + 4'(disp_bytes) + 4'(imm_bytes))));

    a_r1_escape_first: assert property (@(posedge clk) disable iff (!rst_n)
        (done && op_two) |-> (op_first == 8'h0F));

    a_r3_sib_form: assert property (@(posedge clk) disable iff (!rst_n)
        (done && sib_seen) |-> (modrm_seen && modrm[2:0] == 3'd4 && modrm[7:6] != 2'd3));

    a_r4_disp_sizes: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (disp_bytes == 3'd0 || disp_bytes == 3'd1 || disp_bytes == 3'd2 || disp_bytes == 3'd4));

    a_r7_no_imm_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && imm_bytes == 3'd0) |-> (imm_ext == 32'd0));
endmodule

bind insn_field_parser ifp_checker u_ifp_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .done       (done),
    .op_first   (op_first),
    .op_two     (op_two),
    .modrm_seen (modrm_seen),
    .modrm      (modrm),
    .sib_seen   (sib_seen),
    .disp_bytes (disp_bytes),
    .imm_bytes  (imm_bytes),
    .imm_ext    (imm_ext),
    .insn_len   (insn_len)
);

// File: tb/insn_field_parser_bench.sv
`timescale 1ns/1ps
module insn_field_parser_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode32 = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_byte = 8'h00;
    logic        in_ready, done, op_two, modrm_seen, sib_seen;
    logic [7:0]  op_first, op_second, modrm, sib;
    logic [2:0]  disp_bytes, imm_bytes;
    logic [31:0] disp_val, imm_val, imm_ext;
    logic [3:0]  insn_len;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    insn_field_parser u_insn_field_parser (
        .clk(clk), .rst_n(rst_n), .mode32(mode32), .in_valid(in_valid), .in_byte(in_byte),
        .in_ready(in_ready), .done(done), .op_first(op_first), .op_second(op_second),
        .op_two(op_two), .modrm_seen(modrm_seen), .modrm(modrm), .sib_seen(sib_seen),
        .sib(sib), .disp_bytes(disp_bytes), .disp_val(disp_val), .imm_bytes(imm_bytes),
        .imm_val(imm_val), .imm_ext(imm_ext), .insn_len(insn_len)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Class rules written from the requirement text
    task automatic classify(input logic m32, input logic two, input logic [7:0] b,
                            output logic nm, output int il, output logic sx);
        int full;
        full = m32 ? 4 : 2;
        nm = 0; il = 0; sx = 0;
        if (two) begin
            if (b >= 8'h80 && b <= 8'h8F) il = full;
            else if (b >= 8'h90 && b <= 8'hBF) nm = 1;
        end else if (b < 8'h40) begin
            if (b % 8 < 4) nm = 1;
            else if (b % 8 == 4) il = 1;
            else if (b % 8 == 5) il = full;
        end else if (b == 8'h68) il = full;
        else if (b == 8'h6A) begin il = 1; sx = 1; end
        else if (b == 8'h80) begin nm = 1; il = 1; end
        else if (b == 8'h81) begin nm = 1; il = full; end
        else if (b == 8'h83) begin nm = 1; il = 1; sx = 1; end
        else if (b >= 8'h88 && b <= 8'h8B) nm = 1;
        else if (b >= 8'hB0 && b <= 8'hB7) il = 1;
        else if (b >= 8'hB8 && b <= 8'hBF) il = full;
        else if (b == 8'hC6) begin nm = 1; il = 1; end
        else if (b == 8'hC7) begin nm = 1; il = full; end
    endtask

    task automatic run(input logic m32, input logic [7:0] o0, input logic [7:0] o1,
                       input logic [7:0] mr, input logic [7:0] sb, input logic [7:0] seed,
                       input bit gap);
        logic [7:0]  s [12];
        int          n, il, dl, md, rm;
        logic        two, nm, sx, ns;
        logic [31:0] de, ie, xe;
        bit          early;
        two = (o0 == 8'h0F);
        classify(m32, two, two ? o1 : o0, nm, il, sx);
        n = 0; ns = 0; dl = 0; de = 0; ie = 0; early = 0;
        s[n++] = o0;
        if (two) s[n++] = o1;
        if (nm) begin
            s[n++] = mr;
            md = int'(mr[7:6]); rm = int'(mr[2:0]);
            if (m32) begin
                ns = (md != 3) && (rm == 4);
                if (md == 1) dl = 1;
                else if (md == 2) dl = 4;
                else if (md == 0 && (rm == 5 || (ns && sb[2:0] == 3'd5))) dl = 4;
            end else begin
                if (md == 1) dl = 1;
                else if (md == 2) dl = 2;
                else if (md == 0 && rm == 6) dl = 2;
            end
            if (ns) s[n++] = sb;
        end
        for (int k = 0; k < dl; k++) begin
            s[n] = seed ^ 8'(8'h5C + k);
            de = de | (32'(s[n]) << (8 * k));
            n++;
        end
        for (int k = 0; k < il; k++) begin
            s[n] = 8'(seed + 8'(8'h47 * k));
            ie = ie | (32'(s[n]) << (8 * k));
            n++;
        end
        if (sx && il == 1) xe = m32 ? {{24{ie[7]}}, ie[7:0]} : {16'h0, {8{ie[7]}}, ie[7:0]};
        else xe = ie;

        mode32 = m32;
        for (int i = 0; i < n; i++) begin
            if (gap && i > 0) begin
                @(negedge clk);
                in_valid = 1'b0;
                in_byte  = 8'hEE;
            end
            @(negedge clk);
            if (done) early = 1;
            in_valid = 1'b1;
            in_byte  = s[i];
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = 8'hEE;
        chk("R8", "done after last byte", {31'd0, done}, 32'd1);
        chk("R8", "no early done", {31'd0, early}, 32'd0);
        chk("R8", "ready low in done", {31'd0, in_ready}, 32'd0);
        chk("R8", "insn_len", {28'd0, insn_len}, 32'(n));
        chk("R1", "op_first", {24'd0, op_first}, {24'd0, o0});
        chk("R1", "op_two", {31'd0, op_two}, {31'd0, two});
        chk("R1", "op_second", {24'd0, op_second}, two ? {24'd0, o1} : 32'd0);
        chk("R2", "modrm_seen", {31'd0, modrm_seen}, {31'd0, nm});
        chk("R2", "imm_bytes", {29'd0, imm_bytes}, 32'(il));
        chk("R3", "modrm", {24'd0, modrm}, nm ? {24'd0, mr} : 32'd0);
        chk("R3", "sib_seen", {31'd0, sib_seen}, {31'd0, ns});
        chk("R3", "sib", {24'd0, sib}, ns ? {24'd0, sb} : 32'd0);
        chk(m32 ? "R4" : "R5", "disp_bytes", {29'd0, disp_bytes}, 32'(dl));
        chk("R6", "disp_val", disp_val, de);
        chk(gap ? "R9" : "R6", "imm_val", imm_val, ie);
        chk("R7", "imm_ext", imm_ext, xe);
        @(negedge clk);
        chk("R8", "done drops, ready back", {30'd0, done, in_ready}, 32'd1);
    endtask

    initial begin
        int cnt;
        repeat (3) @(negedge clk);
        chk("R8", "reset ready", {31'd0, in_ready}, 32'd1);
        chk("R8", "reset done", {31'd0, done}, 32'd0);
        chk("R8", "reset len", {28'd0, insn_len}, 32'd0);
        rst_n = 1'b1;
        // R9: idle cycles with junk byte and valid low take nothing
        in_byte = 8'h0F;
        repeat (4) @(negedge clk);
        chk("R9", "idle len", {28'd0, insn_len}, 32'd0);
        chk("R9", "idle op_first", {24'd0, op_first}, 32'd0);
        cnt = 0;
        // R1/R2: every first byte in both modes
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 256; b++) begin
                if (b != 16'h0F) begin
                    run(m[0], 8'(b), 8'h00, 8'hC1, 8'h00, 8'(b * 7 + m), (cnt % 3) == 0);
                    cnt++;
                end
            end
        end
        // R1/R2: every second byte after the escape, both modes
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 256; b++) begin
                run(m[0], 8'h0F, 8'(b), 8'hD2, 8'h00, 8'(b + 8'h80), (cnt % 3) == 1);
                cnt++;
            end
        end
        // R3/R4/R5: every addressing byte in both modes
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 256; b++) begin
                run(m[0], 8'h81, 8'h00, 8'(b), 8'(b) ^ 8'hA5, 8'(b * 3), (cnt % 3) == 2);
                cnt++;
            end
        end
        // R3/R4: every scale-index-base byte under mod 0, 1, 2
        for (int md = 0; md < 3; md++) begin
            for (int b = 0; b < 256; b++) begin
                run(1'b1, 8'h83, 8'h00, {2'(md), 6'b000100}, 8'(b), 8'(b ^ 8'h3C), (cnt % 3) == 0);
                cnt++;
            end
        end
        // R7: sign extension of push-byte in 16-bit mode, negative and positive
        run(1'b0, 8'h6A, 8'h00, 8'h00, 8'h00, 8'hF3, 1'b0);
        run(1'b0, 8'h6A, 8'h00, 8'h00, 8'h00, 8'h35, 1'b0);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule